// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is the master side of a three-wire serial EEPROM link (chip select, serial clock, data to the part, data from the part). A host asks for a 16-bit word by presenting a word index with a one-cycle start pulse. The block clocks a read command and the address out to the part, clocks the 16 data bits back, and returns the word with a one-cycle done pulse. The serial clock is derived from the system clock. Each half period lasts a fixed number of system clocks, set by a parameter.

Parts of this kind use either a 6-bit or an 8-bit word address. After every reset the block sends one probe read. The probe assumes the wide address, and the address-complete marker returned by the part shows which width is real. The result is kept for every later access.

A second request input starts a station-address fetch. The block reads three consecutive words from a fixed location and assembles a 48-bit address with the low byte first. It flags the result as invalid when the sum of the three words matches one of the patterns seen with a blank or missing part.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset the block sends one 29-bit probe frame: two zero bits, the start-and-read code 110, eight one bits, then 16 further clocks. `addr_wide` becomes 1 when bit 18 of the 29-bit value sampled during the probe is set, and 0 otherwise. The value is held until the next reset.
- R2: `busy` is high from reset until the probe ends, and from an accepted start until its done pulse. `rd_done` and `sa_done` are single-cycle pulses, and `busy` falls in the same cycle as the pulse.
- R3: A word read holds `eep_cs` high across exactly 19+W serial clock pulses, where W is 6 or 8. The bits sent are 1, 1, 0, then the low W bits of `rd_index` MSB first, then the data phase. `eep_cs` is low while no frame is in progress, and `eep_sk` is never high while `eep_cs` is low.
- R4: `eep_di` changes only while `eep_sk` is low. The bit on `eep_do` is taken while `eep_sk` is high.
- R5: `rd_data` holds the 16 bits sampled on the last 16 clock pulses of the frame, MSB first.
- R6: Every high phase of `eep_sk` lasts exactly HALF_CLKS system clocks. Every low phase inside a frame lasts exactly HALF_CLKS system clocks.
- R7: A start pulse on either request input while `busy` is high is ignored. It causes no frame and no done pulse.
- R8: The station-address fetch reads word indices 0x0A, 0x0B and 0x0C in that order. `sa_addr[15:0]` holds word 0x0A, `[31:16]` holds word 0x0B and `[47:32]` holds word 0x0C. Byte 0 of the address is the low byte of word 0x0A.
- R9: When `sa_done` pulses, `sa_valid` is 0 if the 18-bit sum of the three words is 0 or 0x2FFFD, and 1 otherwise.
- R10: Between two frames, `eep_cs` stays low for at least HALF_CLKS system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | One-cycle request for a word read |
| rd_index | input | 8 | Word index for the read |
| sa_start | input | 1 | One-cycle request for a station-address fetch |
| busy | output | 1 | Probe or request in progress |
| rd_done | output | 1 | Pulse: `rd_data` is valid |
| rd_data | output | 16 | Word returned by the last read |
| sa_done | output | 1 | Pulse: `sa_addr` and `sa_valid` are valid |
| sa_addr | output | 48 | Assembled station address |
| sa_valid | output | 1 | Station address passed the sum check |
| addr_wide | output | 1 | 1 when the part uses 8 address bits |
| eep_cs | output | 1 | EEPROM chip select |
| eep_sk | output | 1 | EEPROM serial clock |
| eep_di | output | 1 | Serial data to the EEPROM |
| eep_do | input | 1 | Serial data from the EEPROM |

## Verification
A behavioural EEPROM model answers both as a 6-bit part and as an 8-bit part. This shows whether the probe tells the two apart, and whether the frame length and address bits then follow the detected width. Indices at zero, at the top of each address range, and above the 6-bit range show that the full address is sent and that the upper bits are truncated in 6-bit mode. Station words with a normal pattern, all zeros, all ones, and all ones minus one separate the two invalid sums from a sum that falls just short of one of them. Requests sent while a read is in progress show that neither request input is queued.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int DATA_W     = 16;
  localparam int IDX_W      = 8;
  localparam int OPC_W      = 3;
  localparam int PROBE_LEAD = 2;
  localparam int NARROW_AW  = 6;
  localparam int WIDE_AW    = 8;
  localparam int FRAME_W    = PROBE_LEAD + OPC_W + WIDE_AW + DATA_W;
  localparam int BITCNT_W   = $clog2(FRAME_W + 1);
  localparam int WIDTH_BIT  = 18;
  localparam int SA_WORDS   = 3;
  localparam int SA_W       = SA_WORDS * DATA_W;
  localparam int SUM_W      = DATA_W + 2;
  localparam int SACNT_W    = $clog2(SA_WORDS);

  localparam logic [OPC_W-1:0]   OP_READ  = 3'b110;
  localparam logic [IDX_W-1:0]   SA_BASE  = 8'h0A;
  localparam logic [SUM_W-1:0]   SUM_BAD  = SUM_W'(SA_WORDS * ((1 << DATA_W) - 1));
  localparam logic [FRAME_W-1:0] PROBE_TX =
    {{PROBE_LEAD{1'b0}}, OP_READ, {WIDE_AW{1'b1}}, {DATA_W{1'b0}}};

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_LOW, ENG_HIGH, ENG_TAIL, ENG_GAP
  } eng_state_e;

  typedef enum logic [2:0] {
    SEQ_PROBE, SEQ_PROBE_W, SEQ_IDLE, SEQ_RD_W, SEQ_SA_GO, SEQ_SA_W, SEQ_SA_END
  } seq_state_e;
endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int HALF_CLKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_CLKS + 1);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(HALF_CLKS)); // R6
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int HALF_CLKS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [BITCNT_W-1:0] nbits,
  input  logic [FRAME_W-1:0]  tx,
  input  logic                sdo,
  output logic                done,
  output logic [FRAME_W-1:0]  rx,
  output logic                cs,
  output logic                sk,
  output logic                di
);
  eng_state_e          st;
  logic [BITCNT_W-1:0] pos;
  logic                tick;
  logic                run;

  assign run = (st != ENG_IDLE);

  mw_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ENG_IDLE;
      cs   <= 1'b0;
      sk   <= 1'b0;
      di   <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
      pos  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ENG_IDLE: if (start) begin
          st  <= ENG_LOW;
          cs  <= 1'b1;
          sk  <= 1'b0;
          di  <= tx[nbits - 1'b1];
          pos <= nbits - 1'b1;
          rx  <= '0;
        end
        ENG_LOW: if (tick) begin
          sk <= 1'b1;
          st <= ENG_HIGH;
        end
        ENG_HIGH: if (tick) begin
          sk <= 1'b0;
          rx <= {rx[FRAME_W-2:0], sdo};
          if (pos == '0) begin
            di <= 1'b0;
            st <= ENG_TAIL;
          end else begin
            pos <= pos - 1'b1;
            di  <= tx[pos - 1'b1];
            st  <= ENG_LOW;
          end
        end
        ENG_TAIL: if (tick) begin
          cs <= 1'b0;
          st <= ENG_GAP;
        end
        ENG_GAP: if (tick) begin
          done <= 1'b1;
          st   <= ENG_IDLE;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  AST_DI_HOLD_SK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(di)); // R4
  AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    sk |-> cs); // R3
  AST_CS_FALL_SK_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(cs) |-> !sk && !$past(sk)); // R3
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_start,
  input  logic [IDX_W-1:0]    rd_index,
  input  logic                sa_start,
  input  logic                frm_done,
  input  logic [FRAME_W-1:0]  frm_rx,
  output logic                frm_start,
  output logic [BITCNT_W-1:0] frm_nbits,
  output logic [FRAME_W-1:0]  frm_tx,
  output logic                busy,
  output logic                rd_done,
  output logic [DATA_W-1:0]   rd_data,
  output logic                sa_done,
  output logic [SA_W-1:0]     sa_addr,
  output logic                sa_valid,
  output logic                addr_wide
);
  seq_state_e          st;
  logic [SACNT_W-1:0]  sa_cnt;
  logic [SUM_W-1:0]    sa_sum;
  logic                probed;
  logic [IDX_W-1:0]    issue_idx;
  logic [FRAME_W-1:0]  rd_tx;
  logic [BITCNT_W-1:0] rd_nb;
  logic                unused_rx;

  assign unused_rx = ^{frm_rx[FRAME_W-1:WIDTH_BIT+1], frm_rx[WIDTH_BIT-1:DATA_W]};
  assign issue_idx = (st == SEQ_SA_GO) ? (SA_BASE + IDX_W'(sa_cnt)) : rd_index;

  always_comb begin
    if (addr_wide) begin
      rd_tx = FRAME_W'({OP_READ, issue_idx, {DATA_W{1'b0}}});
      rd_nb = BITCNT_W'(OPC_W + WIDE_AW + DATA_W);
    end else begin
      rd_tx = FRAME_W'({OP_READ, issue_idx[NARROW_AW-1:0], {DATA_W{1'b0}}});
      rd_nb = BITCNT_W'(OPC_W + NARROW_AW + DATA_W);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SEQ_PROBE;
      frm_start <= 1'b0;
      frm_nbits <= '0;
      frm_tx    <= '0;
      busy      <= 1'b1;
      rd_done   <= 1'b0;
      rd_data   <= '0;
      sa_done   <= 1'b0;
      sa_addr   <= '0;
      sa_valid  <= 1'b0;
      addr_wide <= 1'b0;
      probed    <= 1'b0;
      sa_cnt    <= '0;
      sa_sum    <= '0;
    end else begin
      frm_start <= 1'b0;
      rd_done   <= 1'b0;
      sa_done   <= 1'b0;
      case (st)
        SEQ_PROBE: begin
          frm_start <= 1'b1;
          frm_nbits <= BITCNT_W'(FRAME_W);
          frm_tx    <= PROBE_TX;
          st        <= SEQ_PROBE_W;
        end
        SEQ_PROBE_W: if (frm_done) begin
          addr_wide <= frm_rx[WIDTH_BIT];
          probed    <= 1'b1;
          busy      <= 1'b0;
          st        <= SEQ_IDLE;
        end
        SEQ_IDLE: begin
          if (rd_start) begin
            busy      <= 1'b1;
            frm_start <= 1'b1;
            frm_nbits <= rd_nb;
            frm_tx    <= rd_tx;
            st        <= SEQ_RD_W;
          end else if (sa_start) begin
            busy   <= 1'b1;
            sa_cnt <= '0;
            sa_sum <= '0;
            st     <= SEQ_SA_GO;
          end
        end
        SEQ_RD_W: if (frm_done) begin
          rd_data <= frm_rx[DATA_W-1:0];
          rd_done <= 1'b1;
          busy    <= 1'b0;
          st      <= SEQ_IDLE;
        end
        SEQ_SA_GO: begin
          frm_start <= 1'b1;
          frm_nbits <= rd_nb;
          frm_tx    <= rd_tx;
          st        <= SEQ_SA_W;
        end
        SEQ_SA_W: if (frm_done) begin
          sa_addr <= {frm_rx[DATA_W-1:0], sa_addr[SA_W-1:DATA_W]};
          sa_sum  <= sa_sum + SUM_W'(frm_rx[DATA_W-1:0]);
          if (sa_cnt == SACNT_W'(SA_WORDS - 1)) begin
            st <= SEQ_SA_END;
          end else begin
            sa_cnt <= sa_cnt + 1'b1;
            st     <= SEQ_SA_GO;
          end
        end
        SEQ_SA_END: begin
          sa_valid <= (sa_sum != '0) && (sa_sum != SUM_BAD);
          sa_done  <= 1'b1;
          busy     <= 1'b0;
          st       <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  AST_RD_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (!busy && $past(busy))); // R2
  AST_SA_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    sa_done |-> (!busy && $past(busy))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rd_done || sa_done) |=> !(rd_done || sa_done)); // R2
  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (rst)
    (probed && $past(probed)) |-> $stable(addr_wide)); // R1
  AST_BUSY_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (frm_start && $past(st) != SEQ_PROBE) |-> $past(busy) || $past(rd_start)); // R7
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int HALF_CLKS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic [IDX_W-1:0]  rd_index,
  input  logic              sa_start,
  output logic              busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              sa_done,
  output logic [SA_W-1:0]   sa_addr,
  output logic              sa_valid,
  output logic              addr_wide,
  output logic              eep_cs,
  output logic              eep_sk,
  output logic              eep_di,
  input  logic              eep_do
);
  logic [SYNC_STAGES-1:0] do_sync;
  logic                   sdo;
  logic                   frm_start;
  logic                   frm_done;
  logic [BITCNT_W-1:0]    frm_nbits;
  logic [FRAME_W-1:0]     frm_tx;
  logic [FRAME_W-1:0]     frm_rx;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) do_sync <= '1;
        else     do_sync <= eep_do;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) do_sync <= '1;
        else     do_sync <= {do_sync[SYNC_STAGES-2:0], eep_do};
      end
    end
  endgenerate

  assign sdo = do_sync[SYNC_STAGES-1];

  mw_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .rd_start  (rd_start),
    .rd_index  (rd_index),
    .sa_start  (sa_start),
    .frm_done  (frm_done),
    .frm_rx    (frm_rx),
    .frm_start (frm_start),
    .frm_nbits (frm_nbits),
    .frm_tx    (frm_tx),
    .busy      (busy),
    .rd_done   (rd_done),
    .rd_data   (rd_data),
    .sa_done   (sa_done),
    .sa_addr   (sa_addr),
    .sa_valid  (sa_valid),
    .addr_wide (addr_wide)
  );

  mw_frame #(.HALF_CLKS(HALF_CLKS)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .start (frm_start),
    .nbits (frm_nbits),
    .tx    (frm_tx),
    .sdo   (sdo),
    .done  (frm_done),
    .rx    (frm_rx),
    .cs    (eep_cs),
    .sk    (eep_sk),
    .di    (eep_di)
  );

  AST_NO_FRAME_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> !eep_sk); // R3
endmodule

// File: tb/tb_mw_eeprom_reader.sv
module tb_mw_eeprom_reader;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_start = 1'b0;
  logic [7:0]  rd_index = '0;
  logic        sa_start = 1'b0;
  logic        busy, rd_done, sa_done, sa_valid, addr_wide;
  logic [15:0] rd_data;
  logic [47:0] sa_addr;
  logic        eep_cs, eep_sk, eep_di;
  logic        m_do = 1'b1;

  always #2.5 clk = ~clk;

  mw_eeprom_reader #(.HALF_CLKS(HALF)) dut (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_index(rd_index),
    .sa_start(sa_start), .busy(busy), .rd_done(rd_done), .rd_data(rd_data),
    .sa_done(sa_done), .sa_addr(sa_addr), .sa_valid(sa_valid),
    .addr_wide(addr_wide), .eep_cs(eep_cs), .eep_sk(eep_sk),
    .eep_di(eep_di), .eep_do(m_do)
  );

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // EEPROM model: ignores zeros until the start bit, then 2 code bits,
  // then AW address bits, then a 0 marker and 16 data bits MSB first.
  logic [15:0] mem [256];
  int          m_aw = 8;
  int          m_state = 0, m_cnt = 0, m_pulses = 0;
  logic [1:0]  m_op = '0;
  logic [7:0]  m_addr = '0;
  logic [15:0] m_word = '0;
  int          last_pulses = 0, frames = 0;
  logic [1:0]  last_op = '0;
  logic [7:0]  last_addr = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0137) ^ 16'hA5C3;

  always @(posedge eep_sk or negedge eep_cs) begin
    if (!eep_cs) begin
      last_pulses = m_pulses; last_op = m_op; last_addr = m_addr;
      frames++;
      m_state = 0; m_cnt = 0; m_pulses = 0; m_op = '0; m_addr = '0; m_do = 1'b1;
    end else begin
      m_pulses++;
      case (m_state)
        0: if (eep_di) m_state = 1;
        1: begin
          m_op = {m_op[0], eep_di}; m_cnt++;
          if (m_cnt == 2) begin m_state = 2; m_cnt = 0; end
        end
        2: begin
          m_addr = {m_addr[6:0], eep_di}; m_cnt++;
          if (m_cnt == m_aw) begin
            m_state = 3; m_cnt = 0; m_do = 1'b0; m_word = mem[m_addr];
          end
        end
        3: begin
          m_do = m_word[15 - m_cnt]; m_cnt++;
          if (m_cnt == 16) m_state = 4;
        end
        default: ;
      endcase
    end
  end

  // Phase and gap observers (R4, R6, R10)
  int hi_run = 0, hi_bad = 0, hi_seen = 0, lo_run = 0, lo_bad = 0;
  int gap_run = 0, gap_min = 1000000, di_bad = 0;
  logic prev_sk = 1'b0, prev_di = 1'b0, prev_cs = 1'b0;
  bit   seen_fall = 0;
  always @(negedge clk) begin
    if (rst) begin
      hi_run = 0; lo_run = 0; gap_run = 0; seen_fall = 0;
    end else begin
      if (eep_sk && prev_sk && eep_di !== prev_di) di_bad++;
      if (eep_sk) begin
        if (lo_run != 0 && prev_cs && lo_run != HALF) lo_bad++;
        lo_run = 0; hi_run++;
      end else begin
        if (hi_run != 0) begin
          if (hi_run != HALF) hi_bad++;
          hi_seen++;
        end
        hi_run = 0;
        if (eep_cs) lo_run++; else lo_run = 0;
      end
      if (!eep_cs) gap_run++;
      if (prev_cs && !eep_cs) seen_fall = 1;
      if (eep_cs && !prev_cs) begin
        if (seen_fall && gap_run < gap_min) gap_min = gap_run;
        gap_run = 0;
      end
    end
    prev_sk = eep_sk; prev_di = eep_di; prev_cs = eep_cs;
  end

  // Scoreboard
  typedef struct { bit is_sa; logic [47:0] data; logic valid; } exp_t;
  exp_t exq[$];

  always @(negedge clk) begin
    if (!rst && (rd_done || sa_done)) begin
      if (exq.size() == 0) begin
        chk("R7 unexpected done", 64'(rd_done | sa_done), 64'd0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        if (e.is_sa) begin
          chk("R2 sa_done kind", 64'(sa_done), 64'd1);
          chk("R8 sa_addr", 64'(sa_addr), 64'(e.data));
          chk("R9 sa_valid", 64'(sa_valid), 64'(e.valid));
        end else begin
          chk("R2 rd_done kind", 64'(rd_done), 64'd1);
          chk("R5 rd_data", 64'(rd_data), 64'(e.data));
        end
        chk("R2 busy low at done", 64'(busy), 64'd0);
      end
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!(rd_done || sa_done));
  endtask

  task automatic do_reset(int aw);
    @(negedge clk);
    rst = 1'b1; m_aw = aw;
    repeat (3) @(negedge clk);
    chk("R2 busy in reset", 64'(busy), 64'd1);
    chk("R3 cs low in reset", 64'(eep_cs), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 busy during probe", 64'(busy), 64'd1);
    wait_idle();
    chk("R1 probe length", 64'(last_pulses), 64'd29);
    chk("R1 width flag", 64'(addr_wide), 64'(aw == 8));
  endtask

  task automatic do_read(logic [7:0] idx);
    logic [7:0] a;
    exp_t e;
    wait_idle();
    a = (m_aw == 8) ? idx : (idx & 8'h3F);
    e.is_sa = 0; e.data = 48'(mem[a]); e.valid = 1'b0;
    exq.push_back(e);
    rd_index = idx; rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    wait_done();
    chk("R3 pulse count", 64'(last_pulses), 64'(19 + m_aw));
    chk("R3 read code", 64'(last_op), 64'd2);
    chk("R3 address bits", 64'(last_addr), 64'(a));
  endtask

  task automatic do_station(logic [15:0] w0, logic [15:0] w1, logic [15:0] w2);
    exp_t e;
    logic [17:0] s;
    wait_idle();
    mem[8'h0A] = w0; mem[8'h0B] = w1; mem[8'h0C] = w2;
    s = 18'(w0) + 18'(w1) + 18'(w2);
    e.is_sa = 1; e.data = {w2, w1, w0};
    e.valid = (s != 18'd0) && (s != 18'h2FFFD);
    exq.push_back(e);
    sa_start = 1'b1;
    @(negedge clk);
    sa_start = 1'b0;
    wait_done();
    chk("R8 last word index", 64'(last_addr), 64'h0C);
  endtask

  initial begin
    int f0;
    do_reset(8);                    // R1 wide part
    do_read(8'h00);
    do_read(8'hFF);
    do_read(8'h5A);

    // R7: requests while busy are dropped
    wait_idle();
    f0 = frames;
    begin
      exp_t e;
      e.is_sa = 0; e.data = 48'(mem[8'h12]); e.valid = 1'b0;
      exq.push_back(e);
    end
    rd_index = 8'h12; rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    repeat (3) @(negedge clk);
    rd_index = 8'h34; rd_start = 1'b1; sa_start = 1'b1;
    @(negedge clk); rd_start = 1'b0; sa_start = 1'b0;
    wait_done();
    repeat (200) @(negedge clk);
    chk("R7 no queued request", 64'(exq.size()), 64'd0);
    chk("R7 one frame only", 64'(frames - f0), 64'd1);
    chk("R7 idle after", 64'(busy), 64'd0);

    do_reset(6);                    // R1 narrow part
    do_read(8'h3F);
    do_read(8'h00);
    do_read(8'hC5);                 // R3 upper index bits dropped

    do_station(16'h2301, 16'h6745, 16'hAB89);   // R9 valid
    do_station(16'h0000, 16'h0000, 16'h0000);   // R9 zero sum
    do_station(16'hFFFF, 16'hFFFF, 16'hFFFF);   // R9 all-ones sum
    do_station(16'hFFFF, 16'hFFFF, 16'hFFFE);   // R9 one short

    do_reset(8);
    do_station(16'h1234, 16'h0000, 16'h0001);   // R8 wide mode

    repeat (20) @(negedge clk);
    chk("R4 di stable while sk high", 64'(di_bad), 64'd0);
    chk("R6 high phase length", 64'(hi_bad), 64'd0);
    chk("R6 low phase length", 64'(lo_bad), 64'd0);
    chk("R6 phases seen", 64'(hi_seen > 100), 64'd1);
    chk("R10 cs gap", 64'(gap_min >= HALF), 64'd1);
    chk("R5 scoreboard drained", 64'(exq.size()), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end
endmodule